// File: doc/BRIEF.md
# PC Card Socket Bus Bridge

This block connects a memory-mapped host bus to one PC Card / CompactFlash socket. It takes a 256 MB host window and splits it by the two top offset bits into four 64 MB quarters. The lowest quarter reaches card I/O space. The second quarter is a reserved hole. The third quarter reaches attribute memory and the top quarter reaches common memory. A host access that reaches a card space is handed to the card side with a 2-bit space code and the low 26 offset bits. The host is then held in a wait state until the card acknowledges.

The bridge keeps a card-present flag that is driven by insert and eject request pulses. An insert or eject that does not fit the current slot state is refused with a one-cycle error pulse. While the slot is empty, every access completes at once: a read returns zero and a write is dropped. Two host interrupt lines follow the slot. The card-detect line goes high when a card is inserted. The card interrupt line copies the card's request while a card is present and the line is enabled. An eject clears both lines.

Top module: `pcc_socket_bridge`

## Requirements
- R1: A host offset whose bits [27:26] are 00 reaches the card with space code 00 (I/O) and with card_addr equal to host offset bits [25:0].
- R2: Host offset bits [27:26] = 10 give space code 01 (attribute memory), and 11 give space code 10 (common memory). In both cases card_addr equals offset bits [25:0].
- R3: An access with offset bits [27:26] = 01 (reserved) never raises card_req. It completes in the same cycle as the request, with host_rdy high and read data zero.
- R4: While no card is present, an access to any space never raises card_req. It completes in the same cycle, with host_rdy high and read data zero.
- R5: A forwarded access keeps host_rdy low while card_ack is low. In the cycle card_ack is high, host_rdy is high and host_rdata equals card_rdata. card_we and card_wdata copy host_we and host_wdata.
- R6: An insert pulse on an empty slot sets slot_full and cd_irq from the next cycle, and no error is flagged.
- R7: An insert pulse while a card is present raises slot_err for the next cycle and leaves slot_full and cd_irq unchanged.
- R8: An eject pulse while a card is present clears slot_full, cd_irq and host_irq from the next cycle, even if card_irq_in stays high.
- R9: An eject pulse on an empty slot raises slot_err for the next cycle and leaves the slot empty.
- R10: host_irq equals card_irq_in when irq_en is high and a card is present. Otherwise host_irq is low.
- R11: A synchronous active-high reset clears slot_full, cd_irq and slot_err. host_irq is therefore low after reset.
- R12: When insert and eject pulse in the same cycle, only the insert is evaluated. The eject has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until host_rdy |
| host_we | input | 1 | Host write when high, read when low |
| host_addr | input | 28 | Byte offset inside the 256 MB window |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid with host_rdy |
| host_rdy | output | 1 | Access complete |
| card_req | output | 1 | Card-side request |
| card_we | output | 1 | Card-side write flag |
| card_space | output | 2 | Space code: 00 I/O, 01 attribute, 10 common |
| card_addr | output | 26 | Offset within the selected space |
| card_wdata | output | 16 | Card-side write data |
| card_rdata | input | 16 | Card-side read data |
| card_ack | input | 1 | Card-side acknowledge |
| insert_req | input | 1 | Card insert event pulse |
| eject_req | input | 1 | Card eject event pulse |
| card_irq_in | input | 1 | Card interrupt request level |
| irq_en | input | 1 | Enables the host card interrupt line |
| slot_full | output | 1 | Card present flag |
| slot_err | output | 1 | One-cycle pulse for a refused insert or eject |
| host_irq | output | 1 | Host card interrupt |
| cd_irq | output | 1 | Host card-detect interrupt |

## Verification
The access path is combinational, so the bench checks the results of R1 to R5 shortly after it drives each request. It checks the wait state again after each idle card cycle, and it checks ready and data just after it raises card_ack. The slot results of R6 to R9, R11 and R12 come from one register stage. They are sampled at the falling edge that follows the clock edge on which the request pulse was seen. R10 is combinational from the slot state, so it is checked right after card_irq_in or irq_en changes. The random phase mixes addresses, directions, acknowledge delays and slot events against a bench model of the slot state.

// File: rtl/pcc_bridge_pkg.sv
package pcc_bridge_pkg;

   // Card-side space codes
   typedef enum logic [1:0] {
      SP_IO     = 2'b00,
      SP_ATTR   = 2'b01,
      SP_COMMON = 2'b10,
      SP_NONE   = 2'b11
   } pcc_space_e;

   // Host window quarters, chosen by the two top offset bits
   localparam logic [1:0] WIN_IO     = 2'b00;
   localparam logic [1:0] WIN_RSVD   = 2'b01;
   localparam logic [1:0] WIN_ATTR   = 2'b10;
   localparam logic [1:0] WIN_COMMON = 2'b11;

endpackage

// File: rtl/pcc_addr_decode.sv
module pcc_addr_decode
   import pcc_bridge_pkg::*;
#(
   parameter int SPACE_AW = 26,
   localparam int HOST_AW = SPACE_AW + 2
) (
   input  logic [HOST_AW-1:0]  addr,
   output pcc_space_e          space,
   output logic                hit,
   output logic [SPACE_AW-1:0] offs
);

   assign offs = addr[SPACE_AW-1:0];

   always_comb begin
      space = SP_NONE;
      hit   = 1'b1;
      case (addr[HOST_AW-1 -: 2])
         WIN_IO:     space = SP_IO;
         WIN_ATTR:   space = SP_ATTR;
         WIN_COMMON: space = SP_COMMON;
         default:    hit   = 1'b0;
      endcase
   end

endmodule

// File: rtl/pcc_slot_ctrl.sv
module pcc_slot_ctrl #(
   parameter bit CD_IRQ_PRESENT = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic insert_req,
   input  logic eject_req,
   input  logic card_irq_in,
   input  logic irq_en,
   output logic present,
   output logic op_err,
   output logic host_irq,
   output logic cd_irq
);

   logic ins_ok;
   logic ej_ok;

   // Insert wins when both arrive together
   assign ins_ok = insert_req & ~present;
   assign ej_ok  = ~insert_req & eject_req & present;

   always_ff @(posedge clk) begin
      if (rst) begin
         present <= 1'b0;
         op_err  <= 1'b0;
      end else begin
         op_err <= (insert_req & present) | (~insert_req & eject_req & ~present);
         if (ins_ok)
            present <= 1'b1;
         else if (ej_ok)
            present <= 1'b0;
      end
   end

   assign host_irq = irq_en & present & card_irq_in;

   generate
      if (CD_IRQ_PRESENT) begin : g_cd
         logic cd_q;
         always_ff @(posedge clk) begin
            if (rst)
               cd_q <= 1'b0;
            else if (ins_ok)
               cd_q <= 1'b1;
            else if (ej_ok)
               cd_q <= 1'b0;
         end
         assign cd_irq = cd_q;
      end else begin : g_no_cd
         assign cd_irq = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pcc_access_path.sv
module pcc_access_path
   import pcc_bridge_pkg::*;
#(
   parameter int SPACE_AW   = 26,
   parameter int DATA_W     = 16,
   parameter bit QUIET_IDLE = 1'b1
) (
   input  logic                host_req,
   input  logic                host_we,
   input  logic [DATA_W-1:0]   host_wdata,
   input  pcc_space_e          space,
   input  logic                hit,
   input  logic [SPACE_AW-1:0] offs,
   input  logic                present,
   input  logic [DATA_W-1:0]   card_rdata,
   input  logic                card_ack,
   output logic                card_req,
   output logic                card_we,
   output logic [1:0]          card_space,
   output logic [SPACE_AW-1:0] card_addr,
   output logic [DATA_W-1:0]   card_wdata,
   output logic [DATA_W-1:0]   host_rdata,
   output logic                host_rdy
);

   logic fwd;

   assign fwd        = host_req & hit & present;
   assign card_req   = fwd;
   assign host_rdy   = host_req & (~fwd | card_ack);
   assign host_rdata = (fwd & card_ack & ~host_we) ? card_rdata : '0;

   generate
      if (QUIET_IDLE) begin : g_quiet
         // Card-side buses stay at zero unless a request is forwarded
         assign card_we    = fwd & host_we;
         assign card_space = fwd ? space : SP_IO;
         assign card_addr  = fwd ? offs : '0;
         assign card_wdata = fwd ? host_wdata : '0;
      end else begin : g_pass
         assign card_we    = host_we;
         assign card_space = space;
         assign card_addr  = offs;
         assign card_wdata = host_wdata;
      end
   endgenerate

endmodule

// File: rtl/pcc_socket_bridge.sv
module pcc_socket_bridge
   import pcc_bridge_pkg::*;
#(
   parameter int SPACE_AW       = 26,
   parameter int DATA_W         = 16,
   parameter bit CD_IRQ_PRESENT = 1'b1,
   parameter bit QUIET_IDLE     = 1'b1,
   localparam int HOST_AW       = SPACE_AW + 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                host_req,
   input  logic                host_we,
   input  logic [HOST_AW-1:0]  host_addr,
   input  logic [DATA_W-1:0]   host_wdata,
   output logic [DATA_W-1:0]   host_rdata,
   output logic                host_rdy,
   output logic                card_req,
   output logic                card_we,
   output logic [1:0]          card_space,
   output logic [SPACE_AW-1:0] card_addr,
   output logic [DATA_W-1:0]   card_wdata,
   input  logic [DATA_W-1:0]   card_rdata,
   input  logic                card_ack,
   input  logic                insert_req,
   input  logic                eject_req,
   input  logic                card_irq_in,
   input  logic                irq_en,
   output logic                slot_full,
   output logic                slot_err,
   output logic                host_irq,
   output logic                cd_irq
);

   generate
      if (SPACE_AW < 2 || SPACE_AW > 30) begin : g_bad_aw
         $error("pcc_socket_bridge: SPACE_AW out of range");
      end
      if (DATA_W < 8) begin : g_bad_dw
         $error("pcc_socket_bridge: DATA_W below 8");
      end
   endgenerate

   pcc_space_e          dec_space;
   logic                dec_hit;
   logic [SPACE_AW-1:0] dec_offs;

   pcc_addr_decode #(.SPACE_AW(SPACE_AW)) u_dec (
      .addr  (host_addr),
      .space (dec_space),
      .hit   (dec_hit),
      .offs  (dec_offs)
   );

   pcc_slot_ctrl #(.CD_IRQ_PRESENT(CD_IRQ_PRESENT)) u_slot (
      .clk         (clk),
      .rst         (rst),
      .insert_req  (insert_req),
      .eject_req   (eject_req),
      .card_irq_in (card_irq_in),
      .irq_en      (irq_en),
      .present     (slot_full),
      .op_err      (slot_err),
      .host_irq    (host_irq),
      .cd_irq      (cd_irq)
   );

   pcc_access_path #(
      .SPACE_AW   (SPACE_AW),
      .DATA_W     (DATA_W),
      .QUIET_IDLE (QUIET_IDLE)
   ) u_path (
      .host_req   (host_req),
      .host_we    (host_we),
      .host_wdata (host_wdata),
      .space      (dec_space),
      .hit        (dec_hit),
      .offs       (dec_offs),
      .present    (slot_full),
      .card_rdata (card_rdata),
      .card_ack   (card_ack),
      .card_req   (card_req),
      .card_we    (card_we),
      .card_space (card_space),
      .card_addr  (card_addr),
      .card_wdata (card_wdata),
      .host_rdata (host_rdata),
      .host_rdy   (host_rdy)
   );

endmodule

// File: rtl/pcc_socket_bridge_chk.sv
module pcc_socket_bridge_chk #(
   parameter int SPACE_AW = 26,
   parameter int DATA_W   = 16,
   localparam int HOST_AW = SPACE_AW + 2
) (
   input logic               clk,
   input logic               rst,
   input logic               host_req,
   input logic               host_we,
   input logic [HOST_AW-1:0] host_addr,
   input logic [DATA_W-1:0]  host_rdata,
   input logic               host_rdy,
   input logic               card_req,
   input logic [DATA_W-1:0]  card_rdata,
   input logic               card_ack,
   input logic               insert_req,
   input logic               eject_req,
   input logic               irq_en,
   input logic               slot_full,
   input logic               slot_err,
   input logic               host_irq,
   input logic               cd_irq
);

   assert_rsvd_bypass_R3: assert property (@(posedge clk) disable iff (rst)
      (host_req && host_addr[HOST_AW-1 -: 2] == 2'b01)
         |-> (!card_req && host_rdy && host_rdata == '0));

   assert_empty_bypass_R4: assert property (@(posedge clk) disable iff (rst)
      (host_req && !slot_full) |-> (!card_req && host_rdy && host_rdata == '0));

   assert_wait_state_R5: assert property (@(posedge clk) disable iff (rst)
      (card_req && !card_ack) |-> !host_rdy);

   assert_read_return_R5: assert property (@(posedge clk) disable iff (rst)
      (card_req && card_ack && !host_we) |-> (host_rdy && host_rdata == card_rdata));

   assert_insert_ok_R6: assert property (@(posedge clk) disable iff (rst)
      (insert_req && !slot_full) |=> (slot_full && cd_irq && !slot_err));

   assert_insert_refused_R7: assert property (@(posedge clk) disable iff (rst)
      (insert_req && slot_full) |=> (slot_err && slot_full && $stable(cd_irq)));

   assert_eject_ok_R8: assert property (@(posedge clk) disable iff (rst)
      (eject_req && !insert_req && slot_full) |=> (!slot_full && !cd_irq && !host_irq));

   assert_eject_refused_R9: assert property (@(posedge clk) disable iff (rst)
      (eject_req && !insert_req && !slot_full) |=> (slot_err && !slot_full));

   assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
      (!irq_en || !slot_full) |-> !host_irq);

   assert_reset_clear_R11: assert property (@(posedge clk)
      rst |=> (!slot_full && !cd_irq && !slot_err));

endmodule

bind pcc_socket_bridge pcc_socket_bridge_chk #(
   .SPACE_AW (SPACE_AW),
   .DATA_W   (DATA_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .host_req   (host_req),
   .host_we    (host_we),
   .host_addr  (host_addr),
   .host_rdata (host_rdata),
   .host_rdy   (host_rdy),
   .card_req   (card_req),
   .card_rdata (card_rdata),
   .card_ack   (card_ack),
   .insert_req (insert_req),
   .eject_req  (eject_req),
   .irq_en     (irq_en),
   .slot_full  (slot_full),
   .slot_err   (slot_err),
   .host_irq   (host_irq),
   .cd_irq     (cd_irq)
);

// File: tb/pcc_socket_bridge_test.sv
module pcc_socket_bridge_test;

   localparam int PERIOD = 10;
   localparam int AW     = 26;
   localparam int HAW    = AW + 2;
   localparam int DW     = 16;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           host_req = 1'b0;
   logic           host_we = 1'b0;
   logic [HAW-1:0] host_addr = '0;
   logic [DW-1:0]  host_wdata = '0;
   logic [DW-1:0]  host_rdata;
   logic           host_rdy;
   logic           card_req;
   logic           card_we;
   logic [1:0]     card_space;
   logic [AW-1:0]  card_addr;
   logic [DW-1:0]  card_wdata;
   logic [DW-1:0]  card_rdata = '0;
   logic           card_ack = 1'b0;
   logic           insert_req = 1'b0;
   logic           eject_req = 1'b0;
   logic           card_irq_in = 1'b0;
   logic           irq_en = 1'b0;
   logic           slot_full;
   logic           slot_err;
   logic           host_irq;
   logic           cd_irq;

   int checks = 0;
   int errors = 0;
   bit model_full = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   pcc_socket_bridge uut (
      .clk(clk), .rst(rst),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdy(host_rdy),
      .card_req(card_req), .card_we(card_we), .card_space(card_space),
      .card_addr(card_addr), .card_wdata(card_wdata), .card_rdata(card_rdata),
      .card_ack(card_ack), .insert_req(insert_req), .eject_req(eject_req),
      .card_irq_in(card_irq_in), .irq_en(irq_en), .slot_full(slot_full),
      .slot_err(slot_err), .host_irq(host_irq), .cd_irq(cd_irq)
   );

   function automatic bit exp_fwd(input logic [HAW-1:0] a, input bit full);
      return full && (a[HAW-1 -: 2] != 2'b01);
   endfunction

   function automatic logic [1:0] exp_space(input logic [HAW-1:0] a);
      case (a[HAW-1 -: 2])
         2'b00:   return 2'b00;
         2'b10:   return 2'b01;
         default: return 2'b10;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One host access; the card acknowledges after dly idle cycles
   task automatic access(input bit we, input logic [HAW-1:0] a,
                         input logic [DW-1:0] wd, input int dly,
                         input logic [DW-1:0] rd);
      bit fwd;
      fwd = exp_fwd(a, model_full);
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
      #1;
      if (!fwd) begin
         chk(!card_req, (a[HAW-1 -: 2] == 2'b01) ? "R3 no card_req" : "R4 no card_req",
             32'(card_req), 0);
         chk(host_rdy && host_rdata == '0,
             (a[HAW-1 -: 2] == 2'b01) ? "R3 immediate zero" : "R4 immediate zero",
             {15'd0, host_rdy, host_rdata}, 32'h10000);
      end else begin
         chk(card_req, "R5 card_req", 32'(card_req), 1);
         chk(card_space == exp_space(a),
             (a[HAW-1 -: 2] == 2'b00) ? "R1 space" : "R2 space",
             32'(card_space), 32'(exp_space(a)));
         chk(card_addr == a[AW-1:0],
             (a[HAW-1 -: 2] == 2'b00) ? "R1 offset" : "R2 offset",
             32'(card_addr), 32'(a[AW-1:0]));
         chk(card_we == we && (!we || card_wdata == wd), "R5 write pass",
             {15'd0, card_we, card_wdata}, {15'd0, we, wd});
         for (int i = 0; i < dly; i++) begin
            chk(!host_rdy, "R5 wait state", 32'(host_rdy), 0);
            @(negedge clk);
            #1;
         end
         chk(!host_rdy, "R5 wait state", 32'(host_rdy), 0);
         card_ack = 1'b1; card_rdata = rd;
         #1;
         chk(host_rdy, "R5 ready with ack", 32'(host_rdy), 1);
         if (!we)
            chk(host_rdata == rd, "R5 read data", 32'(host_rdata), 32'(rd));
      end
      @(negedge clk);
      host_req = 1'b0; card_ack = 1'b0; card_rdata = '0;
   endtask

   // Slot event; results are sampled one edge later
   task automatic slot_op(input bit ins, input bit ej, input string tag);
      bit exp_err;
      bit prev_cd;
      exp_err = ins ? model_full : (ej ? !model_full : 1'b0);
      prev_cd = cd_irq;
      if (ins && !model_full)
         model_full = 1'b1;
      else if (!ins && ej && model_full)
         model_full = 1'b0;
      @(negedge clk);
      insert_req = ins; eject_req = ej;
      @(negedge clk);
      insert_req = 1'b0; eject_req = 1'b0;
      #1;
      chk(slot_full == model_full, {tag, " slot_full"}, 32'(slot_full), 32'(model_full));
      chk(slot_err == exp_err, {tag, " slot_err"}, 32'(slot_err), 32'(exp_err));
      if (exp_err)
         chk(cd_irq == prev_cd, {tag, " cd_irq kept"}, 32'(cd_irq), 32'(prev_cd));
      else
         chk(cd_irq == model_full, {tag, " cd_irq"}, 32'(cd_irq), 32'(model_full));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      card_irq_in = 1'b1; irq_en = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(!slot_full && !cd_irq && !slot_err && !host_irq, "R11 reset state",
          {28'd0, slot_full, cd_irq, slot_err, host_irq}, 0);
      @(negedge clk);
      rst = 1'b0;
      card_irq_in = 1'b0;

      // Empty slot: every space bypasses
      access(1'b0, 28'h000_1234, '0, 0, '0);
      access(1'b1, 28'hC00_0010, 16'hBEEF, 0, '0);
      access(1'b0, 28'h800_0004, '0, 0, '0);
      slot_op(1'b0, 1'b1, "R9 eject empty");
      slot_op(1'b1, 1'b0, "R6 insert");
      slot_op(1'b1, 1'b0, "R7 insert full");

      // Directed per-space accesses with a card present
      access(1'b0, 28'h3FF_FFFE, '0, 2, 16'hA5A5);
      access(1'b1, 28'h000_0000, 16'h1357, 0, '0);
      access(1'b0, 28'h800_0000, '0, 1, 16'h0F0F);
      access(1'b0, 28'hFFF_FFFF, '0, 3, 16'h7E81);
      access(1'b0, 28'h400_0000, '0, 0, '0);
      access(1'b1, 28'h7FF_FFFF, 16'hFFFF, 0, '0);

      // Interrupt gating
      @(negedge clk); card_irq_in = 1'b1; irq_en = 1'b0; #1;
      chk(!host_irq, "R10 disabled", 32'(host_irq), 0);
      irq_en = 1'b1; #1;
      chk(host_irq, "R10 passthrough high", 32'(host_irq), 1);
      card_irq_in = 1'b0; #1;
      chk(!host_irq, "R10 passthrough low", 32'(host_irq), 0);
      card_irq_in = 1'b1;
      slot_op(1'b0, 1'b1, "R8 eject");
      chk(!host_irq, "R8 host_irq cleared", 32'(host_irq), 0);
      card_irq_in = 1'b0;

      // Simultaneous requests
      slot_op(1'b1, 1'b1, "R12 both on empty");
      slot_op(1'b1, 1'b1, "R12 both on full");

      // Random phase
      for (int n = 0; n < 300; n++) begin
         int sel;
         sel = int'($urandom_range(0, 9));
         if (sel == 0)
            slot_op(1'b1, 1'b0, model_full ? "R7 rand insert" : "R6 rand insert");
         else if (sel == 1)
            slot_op(1'b0, 1'b1, model_full ? "R8 rand eject" : "R9 rand eject");
         else if (sel == 2) begin
            bit en;
            bit lvl;
            en = 1'($urandom); lvl = 1'($urandom);
            @(negedge clk); irq_en = en; card_irq_in = lvl; #1;
            chk(host_irq == (en & lvl & model_full), "R10 rand irq",
                32'(host_irq), 32'(en & lvl & model_full));
         end else
            access(1'($urandom), HAW'($urandom), DW'($urandom),
                   int'($urandom_range(0, 3)), DW'($urandom));
      end

      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule